// File: doc/BRIEF.md
# Latched Fault, Warning and Peak-Current Register Bank

This block keeps the diagnostic history of a power-supply controller. Single-cycle event pulses for shutdown causes, thermal and fan warnings, per-output over-current warnings and input-side warnings are caught in sticky bits. Each bit holds until software clears it by writing a one to its position. Beside the event bits, one register per current channel keeps the largest sample seen since it was last cleared.

An active-low alert line is driven from the latched bits. Two mask bits in a control register gate it, one for shutdown events and one for warnings, and both come out of reset enabled. A status register keeps a latched copy of the interrupt, so that a short alert is still visible after the fact. A rising edge on the power-on request wipes the event, status and peak history. Losing AC while standby power stays up does not disturb the registers. Reads are combinational from a single address that is shared with the write strobe.

Top module: `fault_latch_bank`

## Requirements
- R1: The shutdown register at address 0x00 latches event inputs into bits 0..7: bit 0 general failure, 1 over-current, 2 over-temperature, 3 AC loss, 4..7 fan 1..4 failure. A set bit stays set, and bits 15:8 read as zero.
- R2: A write to any event register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R3: When an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R4: The warning registers latch like R1. At 0x01, bits 0..1 are control-temperature, 2..3 ambient-temperature and 4..7 fan-slow warnings. At 0x02, bits 0..9 hold one over-current warning per output. At 0x03, bit 0 is input voltage out of range and bit 1 is input current high. All unused bits read as zero.
- R5: One cycle after a rising edge of the power-on request, all event registers, the status register and all peak registers read as zero. Holding the request high or dropping it clears nothing.
- R6: Peak register n, at address 0x08+n, loads sample n when the sample is valid and, taken as unsigned, larger than the stored value. Otherwise it holds.
- R7: Any write to a peak register clears it to zero, whatever the data. A write in the same cycle as a larger sample still leaves zero.
- R8: The control register at 0x05 resets to 0x00C0. alert_n is low exactly when (some shutdown bit is set and control bit 6 is 1) or (some warning bit in 0x01..0x03 is set and control bit 7 is 1).
- R9: Status bit 6 at 0x04 is set on the clock edge after the alert condition holds. Writing 1 to it clears it only when the condition is gone. All other status bits read as zero.
- R10: Reads of unimplemented addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Power-on request; its rising edge clears the history |
| sd_evt | input | 8 | Shutdown event pulses |
| tw_evt | input | 8 | Thermal and fan warning pulses |
| oc_evt | input | NUM_OUT | Per-output over-current warning pulses |
| in_evt | input | 2 | Input voltage and input current warning pulses |
| cur_smp | input | NUM_CUR*SMP_W | Current samples, channel 0 in the low bits |
| cur_vld | input | 1 | Samples valid this cycle |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | DATA_W | Read data for addr |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest case to reach is a clearing write that meets a fresh event or sample in the same clock. The stimulus lines up the event pulse, or a larger peak sample, with the write strobe on one falling edge, so that both land on the same rising edge. A second case needs a particular order of steps: the interrupt latch must be cleared after its source has gone. To get there, the bench first masks the shutdown group while shutdown bits are still set, then clears the warning bits, and only then writes the status clear. Before that point it also tries the clear while the source is active and confirms that the latch holds.

// File: rtl/flb_pkg.sv
package flb_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 16;
  localparam int SD_W     = 8;
  localparam int TW_W     = 8;
  localparam int IN_W     = 2;
  localparam int A_SHDN   = 0;
  localparam int A_THRM   = 1;
  localparam int A_OCW    = 2;
  localparam int A_INW    = 3;
  localparam int A_STAT   = 4;
  localparam int A_CTRL   = 5;
  localparam int A_PEAK0  = 8;
  localparam int STAT_INT = 6;
  localparam int CTRL_SDM = 6;
  localparam int CTRL_WNM = 7;
endpackage

// File: rtl/flb_sticky.sv
module flb_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [W-1:0] set_i,
  input  logic         wr_hit,
  input  logic [W-1:0] wclr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = clr_all | (|set_i) | wr_hit;
    if (clr_all) q_nxt = '0;
    else         q_nxt = set_i | (q & ~(wr_hit ? wclr : {W{1'b0}}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R2: without a clearing write or power-on clear, no set bit drops
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all && !wr_hit) |=> ((q & $past(q)) == $past(q)));

  // R3: an arriving event is held even against a same-cycle clear
  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all && (set_i != '0)) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/flb_peak.sv
module flb_peak #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         vld,
  input  logic [W-1:0] smp,
  output logic [W-1:0] pk
);
  logic [W-1:0] pk_nxt;
  logic         pk_en;

  always_comb begin
    pk_en  = clr | (vld & (smp > pk));
    pk_nxt = clr ? '0 : smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pk <= '0;
    else if (pk_en) pk <= pk_nxt;
  end

  // R6: never decreases unless cleared
  assert_peak_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (pk >= $past(pk)));

  // R6: after a valid sample the stored value covers it
  assert_peak_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr) |=> (pk >= $past(smp)));
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank
  import flb_pkg::*;
#(
  parameter int NUM_OUT = 10,
  parameter int NUM_CUR = 4,
  parameter int SMP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwr_req,
  input  logic [SD_W-1:0]          sd_evt,
  input  logic [TW_W-1:0]          tw_evt,
  input  logic [NUM_OUT-1:0]       oc_evt,
  input  logic [IN_W-1:0]          in_evt,
  input  logic [NUM_CUR*SMP_W-1:0] cur_smp,
  input  logic                     cur_vld,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wr_en,
  output logic [DATA_W-1:0]        rdata,
  output logic                     alert_n
);
  localparam logic [ADDR_W-1:0] AD_SHDN = ADDR_W'(A_SHDN);
  localparam logic [ADDR_W-1:0] AD_THRM = ADDR_W'(A_THRM);
  localparam logic [ADDR_W-1:0] AD_OCW  = ADDR_W'(A_OCW);
  localparam logic [ADDR_W-1:0] AD_INW  = ADDR_W'(A_INW);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);

  logic               pon_q, pon_rise;
  logic [SD_W-1:0]    shdn_q;
  logic [TW_W-1:0]    thrm_q;
  logic [NUM_OUT-1:0] ocw_q;
  logic [IN_W-1:0]    inw_q;
  logic               int_q, int_nxt, int_en;
  logic               sdm_q, wnm_q, ctl_en;
  logic               irq_src;
  logic [SMP_W-1:0]   pk [NUM_CUR];
  logic               unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:NUM_OUT];
  assign pon_rise     = pwr_req & ~pon_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pon_q <= 1'b0;
    else        pon_q <= pwr_req;
  end

  flb_sticky #(.W(SD_W)) u_shdn (
    .clk(clk), .rst_n(rst_n), .clr_all(pon_rise), .set_i(sd_evt),
    .wr_hit(wr_en && addr == AD_SHDN), .wclr(wdata[SD_W-1:0]), .q(shdn_q));

  flb_sticky #(.W(TW_W)) u_thrm (
    .clk(clk), .rst_n(rst_n), .clr_all(pon_rise), .set_i(tw_evt),
    .wr_hit(wr_en && addr == AD_THRM), .wclr(wdata[TW_W-1:0]), .q(thrm_q));

  flb_sticky #(.W(NUM_OUT)) u_ocw (
    .clk(clk), .rst_n(rst_n), .clr_all(pon_rise), .set_i(oc_evt),
    .wr_hit(wr_en && addr == AD_OCW), .wclr(wdata[NUM_OUT-1:0]), .q(ocw_q));

  flb_sticky #(.W(IN_W)) u_inw (
    .clk(clk), .rst_n(rst_n), .clr_all(pon_rise), .set_i(in_evt),
    .wr_hit(wr_en && addr == AD_INW), .wclr(wdata[IN_W-1:0]), .q(inw_q));

  generate
    for (genvar g = 0; g < NUM_CUR; g++) begin : g_peak
      flb_peak #(.W(SMP_W)) u_pk (
        .clk(clk), .rst_n(rst_n),
        .clr(pon_rise | (wr_en && addr == ADDR_W'(A_PEAK0 + g))),
        .vld(cur_vld), .smp(cur_smp[g*SMP_W +: SMP_W]), .pk(pk[g]));
    end
  endgenerate

  // alert source and control masks
  always_comb begin
    irq_src = ((|shdn_q) & sdm_q) | (((|thrm_q) | (|ocw_q) | (|inw_q)) & wnm_q);
    ctl_en  = wr_en && addr == AD_CTRL;
    int_en  = pon_rise | irq_src | (wr_en && addr == AD_STAT);
    if (pon_rise) int_nxt = 1'b0;
    else          int_nxt = irq_src | (int_q & ~wdata[STAT_INT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdm_q <= 1'b1;
      wnm_q <= 1'b1;
    end else if (ctl_en) begin
      sdm_q <= wdata[CTRL_SDM];
      wnm_q <= wdata[CTRL_WNM];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      int_q <= 1'b0;
    else if (int_en) int_q <= int_nxt;
  end

  assign alert_n = ~irq_src;

  always_comb begin
    rdata = '0;
    case (addr)
      AD_SHDN: rdata = DATA_W'(shdn_q);
      AD_THRM: rdata = DATA_W'(thrm_q);
      AD_OCW:  rdata = DATA_W'(ocw_q);
      AD_INW:  rdata = DATA_W'(inw_q);
      AD_STAT: rdata[STAT_INT] = int_q;
      AD_CTRL: begin
        rdata[CTRL_SDM] = sdm_q;
        rdata[CTRL_WNM] = wnm_q;
      end
      default: begin
        for (int i = 0; i < NUM_CUR; i++)
          if (addr == ADDR_W'(A_PEAK0 + i)) rdata = DATA_W'(pk[i]);
      end
    endcase
  end

  // R9: an active alert is latched into the status bit on the next edge
  assert_int_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && !pon_rise) |=> int_q);

  // R5: a power-on rising edge leaves all history cleared
  assert_pon_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pon_rise |=> (shdn_q == '0 && thrm_q == '0 && ocw_q == '0 && inw_q == '0 && !int_q));

  // R8: alert low only with some latched bit present
  assert_alert_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> ((shdn_q != '0) || (thrm_q != '0) || (ocw_q != '0) || (inw_q != '0)));
endmodule

// File: tb/fault_latch_bank_test.sv
module fault_latch_bank_test;
  localparam int NC = 4;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_req;
  logic [7:0]  sd_evt, tw_evt;
  logic [9:0]  oc_evt;
  logic [1:0]  in_evt;
  logic [NC*16-1:0] cur_smp;
  logic        cur_vld;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic        wr_en;
  logic [15:0] rdata;
  logic        alert_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fault_latch_bank uut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .sd_evt(sd_evt),
    .tw_evt(tw_evt), .oc_evt(oc_evt), .in_evt(in_evt), .cur_smp(cur_smp),
    .cur_vld(cur_vld), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .alert_n(alert_n));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [7:0] t, input logic [9:0] o, input logic [1:0] i);
    @(negedge clk);
    sd_evt = s; tw_evt = t; oc_evt = o; in_evt = i;
    @(negedge clk);
    sd_evt = '0; tw_evt = '0; oc_evt = '0; in_evt = '0;
  endtask

  task automatic sample(input int ch, input logic [15:0] v);
    @(negedge clk);
    cur_smp = '0; cur_smp[ch*16 +: 16] = v; cur_vld = 1'b1;
    @(negedge clk);
    cur_vld = 1'b0;
  endtask

  task automatic t_reset;
    rd("R1 reset", 6'h00, 16'h0000);
    rd("R4 reset", 6'h01, 16'h0000);
    rd("R9 reset", 6'h04, 16'h0000);
    rd("R8 ctrl reset", 6'h05, 16'h00C0);
    rd("R6 reset", 6'h08, 16'h0000);
    chk("R8 alert idle", {15'd0, alert_n}, 16'h0001);
  endtask

  task automatic t_shutdown;
    pulse(8'h05, 8'h00, 10'h0, 2'b00);
    rd("R1 latch", 6'h00, 16'h0005);
    chk("R8 alert on shutdown", {15'd0, alert_n}, 16'h0000);
    repeat (3) @(negedge clk);
    rd("R1 hold", 6'h00, 16'h0005);
    pulse(8'hFF, 8'h00, 10'h0, 2'b00);
    rd("R1 all bits", 6'h00, 16'h00FF);
    rd("R9 status latched", 6'h04, 16'h0040);
  endtask

  task automatic t_clear;
    wr(6'h00, 16'h0001);
    rd("R2 clear one", 6'h00, 16'h00FE);
    wr(6'h00, 16'h0000);
    rd("R2 zero write", 6'h00, 16'h00FE);
    @(negedge clk);
    addr = 6'h00; wdata = 16'h0004; wr_en = 1'b1; sd_evt = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; sd_evt = 8'h00;
    rd("R3 event wins", 6'h00, 16'h00FE);
  endtask

  task automatic t_warn;
    pulse(8'h00, 8'h81, 10'h3FF, 2'b11);
    rd("R4 thermal", 6'h01, 16'h0081);
    rd("R4 out current", 6'h02, 16'h03FF);
    rd("R4 input", 6'h03, 16'h0003);
    wr(6'h02, 16'hFFFF);
    rd("R4 cleared", 6'h02, 16'h0000);
  endtask

  task automatic t_irq;
    wr(6'h04, 16'h0040);
    rd("R9 clear blocked", 6'h04, 16'h0040);
    wr(6'h05, 16'h0080);
    chk("R8 shutdown masked, warn live", {15'd0, alert_n}, 16'h0000);
    wr(6'h01, 16'hFFFF);
    wr(6'h03, 16'hFFFF);
    chk("R8 masked alert", {15'd0, alert_n}, 16'h0001);
    wr(6'h04, 16'h0040);
    rd("R9 clear ok", 6'h04, 16'h0000);
    pulse(8'h00, 8'h10, 10'h0, 2'b00);
    chk("R8 warn alert", {15'd0, alert_n}, 16'h0000);
    @(negedge clk);
    rd("R9 warn latched", 6'h04, 16'h0040);
    wr(6'h05, 16'h0000);
    chk("R8 all masked", {15'd0, alert_n}, 16'h0001);
    wr(6'h01, 16'hFFFF);
    wr(6'h04, 16'h0040);
    wr(6'h05, 16'h00C0);
  endtask

  task automatic t_peak;
    sample(0, 16'd100);
    rd("R6 first", 6'h08, 16'd100);
    sample(0, 16'd50);
    rd("R6 smaller", 6'h08, 16'd100);
    sample(0, 16'd300);
    rd("R6 larger", 6'h08, 16'd300);
    sample(3, 16'hFFFF);
    rd("R6 ch3 max", 6'h0B, 16'hFFFF);
    @(negedge clk);
    addr = 6'h08; wdata = 16'h1234; wr_en = 1'b1;
    cur_smp = '0; cur_smp[15:0] = 16'd500; cur_vld = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cur_vld = 1'b0;
    rd("R7 write beats sample", 6'h08, 16'h0000);
    sample(0, 16'd7);
    rd("R7 reload", 6'h08, 16'd7);
  endtask

  task automatic t_pon;
    @(negedge clk);
    pwr_req = 1'b1;
    @(negedge clk);
    rd("R5 shutdown cleared", 6'h00, 16'h0000);
    rd("R5 peak cleared", 6'h0B, 16'h0000);
    rd("R5 status cleared", 6'h04, 16'h0000);
    pulse(8'h02, 8'h00, 10'h0, 2'b00);
    repeat (2) @(negedge clk);
    rd("R5 held high", 6'h00, 16'h0002);
    @(negedge clk);
    pwr_req = 1'b0;
    repeat (2) @(negedge clk);
    rd("R5 drop", 6'h00, 16'h0002);
  endtask

  task automatic t_unimpl;
    wr(6'h3F, 16'hFFFF);
    rd("R10 read zero", 6'h3F, 16'h0000);
    rd("R10 gap read", 6'h06, 16'h0000);
    rd("R10 ctrl intact", 6'h05, 16'h00C0);
    rd("R10 events intact", 6'h00, 16'h0002);
  endtask

  initial begin
    rst_n = 1'b0; pwr_req = 1'b0;
    sd_evt = '0; tw_evt = '0; oc_evt = '0; in_evt = '0;
    cur_smp = '0; cur_vld = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_shutdown;
    t_clear;
    t_warn;
    t_irq;
    t_peak;
    t_pon;
    t_unimpl;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule